// File: doc/BRIEF.md
# Two-Way Latched/Registered Bus Transceiver

This block moves data between an A side and a B side, with one 18-bit path in each direction. Each path has one storage element that works in three ways. It can pass data straight through, it can hold data, or it can capture data on a rising edge of that path's own data clock. Each path also has its own active-low output enable. The A-to-B path and the B-to-A path share only the system clock and the reset.

The pads are outside the block. Each side is given as an input vector, a data output vector and a per-bit drive-enable vector, and the pad ring builds the three-state buffers from these. The data clock of each path and its clock enable are treated as ordinary level signals. The block samples them on the system clock, and a rising edge of the data clock is the sample where it is 1 after a sample where it was 0.

Top module: `dual_path_xcvr`

## Requirements
- R1: When a path's pass-through control is 1, that path's data output equals its input in the same cycle. This holds for any level of that path's data clock and clock enable.
- R2: When pass-through is 0 and the active-low clock enable is 0, the storage loads the input at the system clock edge that first samples the data clock as 1 after it was sampled as 0.
- R3: When pass-through is 0 and the clock enable is 1, the stored value does not change, even when the data clock rises.
- R4: When pass-through is 0 and the data clock keeps a static level, with no 0-to-1 step between samples, the stored value does not change.
- R5: When pass-through falls to 0, the value held is the last input value that was passing through before the fall.
- R6: The active-low output enable sets every bit of that side's drive-enable vector to 1 when it is 0 and to 0 when it is 1. A drive-enable of 0 means the side is high-impedance.
- R7: The output enable affects only the drive-enable vector. The storage keeps updating while the outputs are disabled, and the data output vector keeps showing the path value.
- R8: While reset is active, both stored values are 0 and both drive-enable vectors are 0. After reset, the data clock counts as previously sampled 1, so a data clock that is already high gives no capture.
- R9: The two paths are independent, and each path carries 18 bits. The A-to-B path drives the B outputs from the A input. The B-to-A path drives the A outputs from the B input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the controls |
| rst_n | input | 1 | Active-low reset |
| a_in | input | 18 | Data arriving on the A side |
| a_out | output | 18 | B-to-A path value for the A pads |
| a_oe | output | 18 | A side drive enables, 1 = drive |
| b_in | input | 18 | Data arriving on the B side |
| b_out | output | 18 | A-to-B path value for the B pads |
| b_oe | output | 18 | B side drive enables, 1 = drive |
| ab_pass | input | 1 | A-to-B pass-through control |
| ab_dclk | input | 1 | A-to-B data clock level |
| ab_cke_n | input | 1 | A-to-B clock enable, active low |
| ab_oe_n | input | 1 | Output enable for the B side, active low |
| ba_pass | input | 1 | B-to-A pass-through control |
| ba_dclk | input | 1 | B-to-A data clock level |
| ba_cke_n | input | 1 | B-to-A clock enable, active low |
| ba_oe_n | input | 1 | Output enable for the A side, active low |

## Verification
The assertions assume that every control and data input changes only between system clock edges, so each sample sees a settled level. They also assume that the data clock is slow enough that the system clock samples every rising edge. The stimulus changes inputs only on the falling system clock edge, one step at a time. It walks each path through all sixteen control combinations in a changing order, so that data-clock rises, clock-enable blocking and pass-through falls all occur next to each other.

// File: rtl/dual_path_xcvr.sv
module dual_path_xcvr #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe,
  input  logic         ab_pass,
  input  logic         ab_dclk,
  input  logic         ab_cke_n,
  input  logic         ab_oe_n,
  input  logic         ba_pass,
  input  logic         ba_dclk,
  input  logic         ba_cke_n,
  input  logic         ba_oe_n
);
  localparam int NDIR = 2;

  logic [NDIR-1:0][W-1:0] din, dout, held;
  logic [NDIR-1:0] pass, dclk, cke_n, oe_n, dclk_q, load, drv;

  assign din   = {b_in, a_in};
  assign pass  = {ba_pass, ab_pass};
  assign dclk  = {ba_dclk, ab_dclk};
  assign cke_n = {ba_cke_n, ab_cke_n};
  assign oe_n  = {ba_oe_n, ab_oe_n};

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    assign load[d] = ~pass[d] & ~cke_n[d] & dclk[d] & ~dclk_q[d];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        held[d]   <= '0;
        dclk_q[d] <= 1'b1;
      end else begin
        dclk_q[d] <= dclk[d];
        if (pass[d] || load[d]) held[d] <= din[d];
      end
    end

    assign dout[d] = pass[d] ? din[d] : held[d];
    assign drv[d]  = rst_n & ~oe_n[d];

    a_r1_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
      pass[d] |-> dout[d] == din[d]);
    a_r2_edge_load: assert property (@(posedge clk) disable iff (!rst_n)
      (!pass[d] && !cke_n[d] && dclk[d] && !dclk_q[d]) |=> held[d] == $past(din[d]));
    a_r3_cke_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (!pass[d] && cke_n[d]) |=> $stable(held[d]));
    a_r4_no_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!pass[d] && dclk[d] == dclk_q[d]) |=> $stable(held[d]));
    a_r5_close_value: assert property (@(posedge clk) disable iff (!rst_n)
      pass[d] |=> held[d] == $past(din[d]));
  end

  assign b_out = dout[0];
  assign a_out = dout[1];
  assign b_oe  = {W{drv[0]}};
  assign a_oe  = {W{drv[1]}};

  a_r6_off_when_high: assert property (@(posedge clk) disable iff (!rst_n)
    (ab_oe_n |-> b_oe == '0) and (ba_oe_n |-> a_oe == '0));
  a_r6_on_when_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_oe_n |-> &b_oe) and (!ba_oe_n |-> &a_oe));
  a_r8_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (a_oe == '0 && b_oe == '0));
endmodule

// File: tb/dual_path_xcvr_tb_top.sv
module dual_path_xcvr_tb_top;
  localparam int W = 18;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0, a_out, a_oe, b_out, b_oe;
  logic ab_pass = 0, ab_dclk = 0, ab_cke_n = 1, ab_oe_n = 0;
  logic ba_pass = 0, ba_dclk = 0, ba_cke_n = 1, ba_oe_n = 0;
  int nvec = 0, nbad = 0;

  // bench reference state, index 0 = A-to-B, 1 = B-to-A
  logic [W-1:0] ref_q [2];
  logic ref_pd [2];
  int ref_tag [2];

  always #2 clk = ~clk;

  dual_path_xcvr #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
    .ab_pass(ab_pass), .ab_dclk(ab_dclk), .ab_cke_n(ab_cke_n), .ab_oe_n(ab_oe_n),
    .ba_pass(ba_pass), .ba_dclk(ba_dclk), .ba_cke_n(ba_cke_n), .ba_oe_n(ba_oe_n));

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string tagname(input int t);
    case (t)
      1: return "R1"; 2: return "R2"; 3: return "R3"; 5: return "R5"; 8: return "R8";
      default: return "R4";
    endcase
  endfunction

  function automatic logic [W-1:0] expo(input int d, input logic p, input logic [W-1:0] x);
    return p ? x : ref_q[d];
  endfunction

  task automatic check_all();
    chk(ab_pass ? "R1 b_out" : {tagname(ref_tag[0]), " b_out"}, b_out, expo(0, ab_pass, a_in));
    chk(ba_pass ? "R1 a_out" : {tagname(ref_tag[1]), " a_out"}, a_out, expo(1, ba_pass, b_in));
    chk("R6 b_oe", b_oe, rst_n && !ab_oe_n ? {W{1'b1}} : '0);
    chk("R6 a_oe", a_oe, rst_n && !ba_oe_n ? {W{1'b1}} : '0);
  endtask

  task automatic upd(input int d, input logic p, input logic c, input logic k, input logic [W-1:0] x);
    if (!rst_n) begin
      ref_q[d] = '0; ref_pd[d] = 1'b1; ref_tag[d] = 8;
    end else begin
      if (p) begin ref_q[d] = x; ref_tag[d] = 5; end
      else if (!k && c && !ref_pd[d]) begin ref_q[d] = x; ref_tag[d] = 2; end
      else if (k) ref_tag[d] = (ref_tag[d] == 5) ? 5 : 3;
      else ref_tag[d] = (ref_tag[d] == 5) ? 5 : 4;
      ref_pd[d] = c;
    end
  endtask

  task automatic step();
    #1 check_all();
    @(posedge clk);
    upd(0, ab_pass, ab_dclk, ab_cke_n, a_in);
    upd(1, ba_pass, ba_dclk, ba_cke_n, b_in);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    ref_q[0] = '0; ref_q[1] = '0; ref_pd[0] = 1; ref_pd[1] = 1; ref_tag[0] = 8; ref_tag[1] = 8;
    // R8: reset clears storage and disables drive even with oe_n low
    @(negedge clk);
    a_in = 18'h2AAAA; b_in = 18'h15555;
    step(); step();
    chk("R8 b_out", b_out, '0);
    chk("R8 a_oe", a_oe, '0);
    rst_n = 1'b1;
    // R8: data clock already high after reset gives no capture
    ab_dclk = 1; ab_cke_n = 0; step();
    chk("R8 no capture at release", b_out, '0);
    // R2: clocked capture then R3 blocked edge, R7 disabled outputs still update
    ab_dclk = 0; ab_oe_n = 1; step();
    a_in = 18'h3C0F1; ab_dclk = 1; step();
    chk("R7 capture with oe off", b_out, 18'h3C0F1);
    chk("R7 b_oe off", b_oe, '0);
    ab_oe_n = 0; ab_dclk = 0; ab_cke_n = 1; step();
    a_in = 18'h00777; ab_dclk = 1; step();
    chk("R3 edge blocked", b_out, 18'h3C0F1);
    // R5 and R9: B-to-A pass-through fall, A-to-B unaffected
    ba_pass = 1; b_in = 18'h1BEEF; step();
    chk("R9 a_out from b_in", a_out, 18'h1BEEF);
    chk("R9 b_out independent", b_out, 18'h3C0F1);
    ba_pass = 0; b_in = 18'h00001; step();
    chk("R5 held after fall", a_out, 18'h1BEEF);
    // sweep of all control combinations with varied data
    for (int i = 0; i < 4096; i++) begin
      logic [3:0] ca, cb;
      ca = 4'((i * 5 + i / 16) % 16);
      cb = 4'((i * 7 + i / 32 + 3) % 16);
      ab_pass = ca[0]; ab_dclk = ca[1]; ab_cke_n = ca[2]; ab_oe_n = ca[3];
      ba_pass = cb[0]; ba_dclk = cb[1]; ba_cke_n = cb[2]; ba_oe_n = cb[3];
      a_in = W'((i * 40503 + 17) ^ (i << 9));
      b_in = W'((i * 26417 + 5) ^ (i >> 2));
      step();
    end
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule